// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches the live calendar time and raises an alarm when the time reaches a programmed moment. It holds no time of its own. A time counter elsewhere supplies the current BCD second, minute, hour, day-of-month and weekday fields. It also supplies a one-cycle update strobe after each increment. Five alarm bytes, one for each field, arrive as plain inputs. Each byte carries an active-low include bit that enables that field's comparison.

The comparison is evaluated only on the update strobe. An alarm event happens at the first strobe where every included field equals the current time and the previous strobe's evaluation did not match. The event sets a sticky flag, which the host clears with a one-cycle strobe. A match that persists across several updates produces a single event, so a cleared flag returns only after the time leaves and then re-enters the matching state. The interrupt request is the flag gated by an enable, as a level.

Top module: `cal_alarm_match`

## Requirements
- R1: After synchronous active-low reset, `alarm_flag` and `irq` are 0. The stored "previous evaluation matched" state is cleared, so the first matching update after reset raises the flag.
- R2: Bit 7 of each alarm byte is the include bit; 0 includes the field, 1 excludes it. Only the low bits of each byte take part in the comparison: 7 bits for seconds and minutes, 6 bits for hour and day, 3 bits for weekday. Any bits between those and bit 7 are ignored.
- R3: On a cycle with `upd` high, the flag is set at that clock edge when two conditions hold. At least one field is included, and every included field equals its time input. In addition, the previous `upd` evaluation did not match.
- R4: When all five include bits are 1, the flag is never set, whatever the time inputs.
- R5: The flag stays set until a cycle with `flag_clr` high and no new alarm event. The flag is then 0 after that clock edge.
- R6: After a clear, updates whose evaluation still matches do not set the flag again. It is set again only after an update that does not match, followed by an update that matches.
- R7: Time and alarm inputs have no effect on cycles without `upd`. Matching values present without the strobe leave the flag at 0, and they do not change the remembered match state.
- R8: The hour comparison covers all 6 hour bits as given, so the 12-hour AM/PM bit (bit 5) must agree. For example, 0x32 (12 PM) does not match 0x12 (12 AM).
- R9: `irq` equals `alarm_flag AND irq_en` as a combinational level.
- R10: A new alarm event in the same cycle as `flag_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd | input | 1 | One-cycle strobe after each time increment |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD, 12/24-hour encoding |
| now_day | input | 6 | Current day of month, BCD |
| now_wday | input | 3 | Current weekday 0..6 |
| alm_sec | input | 8 | Second alarm byte, bit 7 include_n |
| alm_min | input | 8 | Minute alarm byte, bit 7 include_n |
| alm_hour | input | 8 | Hour alarm byte, bit 7 include_n |
| alm_day | input | 8 | Day alarm byte, bit 7 include_n |
| alm_wday | input | 8 | Weekday alarm byte, bit 7 include_n |
| flag_clr | input | 1 | Host strobe clearing the flag |
| irq_en | input | 1 | Alarm interrupt enable |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt request level |

## Verification
Several behaviours are checked by assertions on every cycle. The flag holds without a clear, and it falls after a clear when no event coincides. It never rises without the update strobe, and it never rises while no field is included. A coincident event always leaves the flag set. The exact matching rules can only be shown by the bench's scenarios. These include the per-field masking with its ignored spare bits, the AM/PM sensitivity of the hour, and the single-event behaviour of a persistent match. The bench sweeps every include mask against every pattern of matching and mismatching fields and compares the results with an arithmetic reference.

// File: rtl/alarm_pkg.sv
// Package: shared widths and field layout for the calendar alarm comparator.
// Assumes five fields in a fixed index order: sec, min, hour, day, weekday.
package alarm_pkg;
    localparam int NUM_FIELDS = 5;
    localparam int REG_W      = 8;
    localparam int INC_BIT    = REG_W - 1;
    localparam int MAX_FW     = REG_W - 1;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_WDAY = 4;

    // Compared width of each field index.
    function automatic int field_width(input int idx);
        case (idx)
            F_SEC, F_MIN:  return 7;
            F_HOUR, F_DAY: return 6;
            default:       return 3;
        endcase
    endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
// Module: one field comparator.
// Compares the low FW bits of the alarm byte with the time value.
// Assumes the time value is zero-extended to MAX_FW bits. The include bit
// is active low, and an excluded field always reports a hit.
module alarm_field_cmp
    import alarm_pkg::*;
#(
    parameter int FW = 7
) (
    input  logic [MAX_FW-1:0] now_val,
    input  logic [REG_W-1:0]  alm_reg,
    output logic              used,
    output logic              hit
);
    localparam logic [MAX_FW-1:0] CMP_MASK = MAX_FW'((1 << FW) - 1);

    // Decode the include bit and compare the masked field.
    always_comb begin
        used = ~alm_reg[INC_BIT];
        hit  = ~used | (((now_val ^ alm_reg[MAX_FW-1:0]) & CMP_MASK) == '0);
    end
endmodule

// File: rtl/alarm_hit_reduce.sv
// Module: combines per-field results into one match.
// Assumes excluded fields already report a hit. There is no match when no
// field is included.
module alarm_hit_reduce #(
    parameter int N = 5
) (
    input  logic [N-1:0] used,
    input  logic [N-1:0] hit,
    output logic         all_hit
);
    // Match only when at least one field is included and all fields hit.
    always_comb all_hit = (|used) & (&hit);
endmodule

// File: rtl/alarm_flag_ctl.sv
// Module: sticky flag with first-match detection.
// Samples the match only on the update strobe and remembers the last
// sampled result. It sets the flag when the match rises. A set takes
// priority over a host clear in the same cycle.
module alarm_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic all_hit,
    input  logic flag_clr,
    output logic flag
);
    logic prev_hit;
    logic set_ev;

    // Alarm event: matching update whose predecessor did not match.
    always_comb set_ev = upd & all_hit & ~prev_hit;

    // Remember the match result of the last update.
    always_ff @(posedge clk) begin
        if (!rst_n)   prev_hit <= 1'b0;
        else if (upd) prev_hit <= all_hit;
    end

    // Sticky flag: set on event, cleared by host, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (set_ev)    flag <= 1'b1;
        else if (flag_clr)  flag <= 1'b0;
    end

    // R5: flag holds while no clear arrives
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !flag_clr |=> flag);
    // R5: clear without a new event drops the flag
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !(upd && all_hit) |=> !flag);
    // R7: without the update strobe a low flag stays low
    p_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !upd |=> !flag);
    // R10: an update that matches after a non-matching one leaves the flag set
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd && all_hit && !prev_hit |=> flag);
endmodule

// File: rtl/cal_alarm_match.sv
// Module: top of the masked calendar alarm comparator.
// Generates one comparator per field, reduces them, and drives the sticky
// flag and the gated interrupt level. Assumes the time inputs are valid
// whenever upd is high.
module cal_alarm_match
    import alarm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [6:0]       now_sec,
    input  logic [6:0]       now_min,
    input  logic [5:0]       now_hour,
    input  logic [5:0]       now_day,
    input  logic [2:0]       now_wday,
    input  logic [REG_W-1:0] alm_sec,
    input  logic [REG_W-1:0] alm_min,
    input  logic [REG_W-1:0] alm_hour,
    input  logic [REG_W-1:0] alm_day,
    input  logic [REG_W-1:0] alm_wday,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic             alarm_flag,
    output logic             irq
);
    logic [MAX_FW-1:0]     now_v [NUM_FIELDS];
    logic [REG_W-1:0]      alm_v [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] f_used;
    logic [NUM_FIELDS-1:0] f_hit;
    logic                  all_hit;

    // Gather fields into index order with zero extension.
    always_comb begin
        now_v[F_SEC]  = now_sec;
        now_v[F_MIN]  = now_min;
        now_v[F_HOUR] = {1'b0, now_hour};
        now_v[F_DAY]  = {1'b0, now_day};
        now_v[F_WDAY] = {4'b0, now_wday};
        alm_v[F_SEC]  = alm_sec;
        alm_v[F_MIN]  = alm_min;
        alm_v[F_HOUR] = alm_hour;
        alm_v[F_DAY]  = alm_day;
        alm_v[F_WDAY] = alm_wday;
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam int FW = field_width(i);
        alarm_field_cmp #(.FW(FW)) u_cmp (
            .now_val (now_v[i]),
            .alm_reg (alm_v[i]),
            .used    (f_used[i]),
            .hit     (f_hit[i])
        );
    end

    alarm_hit_reduce #(.N(NUM_FIELDS)) u_reduce (
        .used    (f_used),
        .hit     (f_hit),
        .all_hit (all_hit)
    );

    alarm_flag_ctl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .all_hit  (all_hit),
        .flag_clr (flag_clr),
        .flag     (alarm_flag)
    );

    // Interrupt request level.
    always_comb irq = alarm_flag & irq_en;

    // R4: with every field excluded an update never raises the flag
    p_none_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_flag && alm_sec[INC_BIT] && alm_min[INC_BIT] && alm_hour[INC_BIT]
        && alm_day[INC_BIT] && alm_wday[INC_BIT] |=> !alarm_flag);
endmodule

// File: tb/tb_cal_alarm_match.sv
module tb_cal_alarm_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0;
    logic [5:0] now_hour = '0, now_day = '0;
    logic [2:0] now_wday = '0;
    logic [7:0] alm_sec = 8'h80, alm_min = 8'h80, alm_hour = 8'h80, alm_day = 8'h80, alm_wday = 8'h80;
    logic       flag_clr = 1'b0, irq_en = 1'b0;
    logic       alarm_flag, irq;

    int checks = 0, failures = 0;
    logic e_flag = 1'b0, e_prev = 1'b0, done = 1'b0;

    cal_alarm_match dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic ref_match();
        logic any_inc = 1'b0;
        logic ok = 1'b1;
        if (!alm_sec[7])  begin any_inc = 1; ok &= (alm_sec[6:0]  == now_sec);  end
        if (!alm_min[7])  begin any_inc = 1; ok &= (alm_min[6:0]  == now_min);  end
        if (!alm_hour[7]) begin any_inc = 1; ok &= (alm_hour[5:0] == now_hour); end
        if (!alm_day[7])  begin any_inc = 1; ok &= (alm_day[5:0]  == now_day);  end
        if (!alm_wday[7]) begin any_inc = 1; ok &= (alm_wday[2:0] == now_wday); end
        return any_inc & ok;
    endfunction

    // One cycle of stimulus, reference update, then check at the next negedge.
    task automatic step(input logic t, input logic c, input logic ie, input string req);
        logic m;
        @(negedge clk);
        upd = t; flag_clr = c; irq_en = ie;
        m = ref_match();
        if (t && m && !e_prev) e_flag = 1'b1;
        else if (c) e_flag = 1'b0;
        if (t) e_prev = m;
        @(negedge clk);
        upd = 1'b0; flag_clr = 1'b0;
        chk(alarm_flag, e_flag, req);
        chk(irq, e_flag & ie, "R9 irq level");
    endtask

    task automatic set_alarm(input logic [4:0] inc);
        alm_sec  = {~inc[0], 7'h45};
        alm_min  = {~inc[1], 7'h10};
        alm_hour = {~inc[2], 1'b1, 6'h23};      // R2: spare bit 6 set, ignored
        alm_day  = {~inc[3], 1'b1, 6'h31};
        alm_wday = {~inc[4], 4'b1010, 3'd6};
    endtask

    task automatic set_time(input logic [4:0] eq);
        now_sec  = eq[0] ? 7'h45 : 7'h44;
        now_min  = eq[1] ? 7'h10 : 7'h11;
        now_hour = eq[2] ? 6'h23 : 6'h22;
        now_day  = eq[3] ? 6'h31 : 6'h30;
        now_wday = eq[4] ? 3'd6  : 3'd7;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(alarm_flag, 1'b0, "R1 reset flag");
        chk(irq, 1'b0, "R1 reset irq");

        // R7: matching values without the strobe do nothing
        set_alarm(5'b00010); set_time(5'b11111);
        step(1'b0, 1'b0, 1'b1, "R7 no strobe");
        step(1'b1, 1'b0, 1'b1, "R1 R3 first match after reset");

        // R6: persistent match gives one event
        step(1'b0, 1'b1, 1'b1, "R5 clear");
        step(1'b1, 1'b0, 1'b1, "R6 no re-set while matching");
        step(1'b1, 1'b0, 1'b1, "R6 still matching");
        set_time(5'b00000);
        step(1'b1, 1'b0, 1'b1, "R6 leave match");
        set_time(5'b11111);
        step(1'b1, 1'b0, 1'b1, "R6 re-enter match");

        // R10: event and clear together
        set_time(5'b00000);
        step(1'b1, 1'b1, 1'b0, "R5 clear with non-matching update");
        set_time(5'b11111);
        step(1'b1, 1'b1, 1'b1, "R10 set wins over clear");

        // R8: AM/PM bit must agree
        step(1'b0, 1'b1, 1'b1, "R5 clear before hour test");
        alm_sec = 8'h80; alm_min = 8'h80; alm_day = 8'h80; alm_wday = 8'h80;
        alm_hour = 8'h32; now_hour = 6'h12;
        step(1'b1, 1'b0, 1'b1, "R8 12PM vs 12AM no match");
        chk(alarm_flag, 1'b0, "R8 AM/PM mismatch");
        now_hour = 6'h32;
        step(1'b1, 1'b0, 1'b1, "R8 PM hour match");
        chk(alarm_flag, 1'b1, "R8 PM hour match flag");

        // R4: all excluded
        step(1'b0, 1'b1, 1'b1, "R5 clear");
        alm_hour = 8'hB2;
        step(1'b1, 1'b0, 1'b1, "R4 none included");
        chk(alarm_flag, 1'b0, "R4 none included flag");

        // Sweep: every include mask against every match pattern (R2 R3 R4 R5 R10)
        for (int m = 0; m < 32; m++) begin
            set_alarm(5'(m));
            for (int p = 0; p < 32; p++) begin
                set_time(5'(p));
                step(1'b1, (p % 4) == 3, (p % 3) != 0, "R3 sweep");
            end
            set_time(5'b00000);
            step(1'b1, 1'b1, 1'b1, "R5 sweep clear");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule